// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer arithmetic and logic unit of a small processor datapath. Each cycle in which `exec_en` is high, it takes an operation code and two operands and produces a result, a strobe that says whether the result should be written to the register file, and the new value of a five-bit status word. The caller extends any immediate value before it reaches the operand ports. The multiplier, the divider and the register file sit outside this block.

The operations are: addition; subtraction in both operand orders; a compare that only sets flags; saturating addition and subtraction; AND, OR, XOR and NOT; and left, logical right and arithmetic right shifts. Each group of operations updates its own subset of the flags. Zero, sign, carry and overflow are recomputed on every arithmetic operation. Logical operations keep the carry. Shifts load the carry with the last bit that left the word. The saturation flag is sticky: it is set when a saturating operation clamps its result, and only reset clears it.

`result`, `res_wr` and `flg_next` are combinational from the inputs and the stored status. The stored status `stat_q` takes the value of `flg_next` on the rising clock edge when `exec_en` is high.

Top module: `flagged_alu`

## Requirements
- R1: Operation code 0 (add) gives a+b modulo 2^32. Carry is set when the unsigned sum wraps. Overflow is set when a and b have the same sign and the result sign differs from it.
- R2: Code 1 gives a-b and code 2 gives b-a. For minuend x and subtrahend y, carry is set when x < y unsigned, and overflow is set when x and y differ in sign and the result sign differs from that of x.
- R3: Code 3 (compare) sets zero, sign, carry and overflow as code 1 does, and holds `res_wr` low.
- R4: Code 4 (saturating add) and code 5 (saturating a-b) work as codes 0 and 1. On overflow they clamp the result to 0x7FFFFFFF when the wrapped result is negative and to 0x80000000 when it is non-negative. They also set overflow and the saturation flag.
- R5: The saturation flag (status bit 4) is cleared only by reset. No operation other than a clamping one changes it.
- R6: Codes 6 (a AND b), 7 (a OR b), 8 (a XOR b) and 9 (NOT a) update zero and sign, clear overflow and keep carry unchanged.
- R7: Codes 10 (shift a left), 11 (shift a right, logical) and 12 (shift a right, arithmetic) shift by b[4:0] and ignore the upper bits of b. They clear overflow. For a left shift by n, carry is a[32-n]. For a right shift by n, carry is a[n-1].
- R8: A shift by zero returns a unchanged and clears carry.
- R9: Zero (status bit 0) is set when the final, post-clamp result is zero. Sign (status bit 1) is bit 31 of that result. Overflow is status bit 2 and carry is status bit 3.
- R10: When `exec_en` is low, or the code is 13 to 15, `res_wr` is low and the stored status does not change.
- R11: Reset clears all five status bits. `stat_q` takes `flg_next` on each rising edge at which `exec_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute the presented operation this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or the shift amount in bits 4:0 |
| result | output | 32 | Operation result |
| res_wr | output | 1 | Result write strobe |
| flg_next | output | 5 | Status value after this operation: {sat, carry, ovf, sign, zero} |
| stat_q | output | 5 | Stored status, same layout |

## Verification
The adder is driven with operand pairs chosen so that signed overflow and unsigned carry can be told apart: maximum positive plus one overflows without a carry, and all-ones plus one carries without overflowing. Subtraction runs in both operand orders with a borrow-producing pair and a negative-minus-one pair, so a swapped order or an inverted borrow shows up. Saturating operations are tried in both clamp directions, followed by ordinary operations that must leave the sticky flag set. A carry planted in the flags is then carried through a run of logical operations. Shifts are tried in all three kinds at amounts 0, 1, 4 and 31, with garbage in the upper amount bits. Each shift puts a distinct bit into the carry, which exposes off-by-one bit selection.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_RSUB = 4'd2,
      OP_CMP  = 4'd3,
      OP_SADD = 4'd4,
      OP_SSUB = 4'd5,
      OP_AND  = 4'd6,
      OP_OR   = 4'd7,
      OP_XOR  = 4'd8,
      OP_NOT  = 4'd9,
      OP_SHL  = 4'd10,
      OP_SHR  = 4'd11,
      OP_SAR  = 4'd12
   } alu_op_e;

   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_ARITH = 3'd1,
      CLS_SAT   = 3'd2,
      CLS_LOGIC = 3'd3,
      CLS_SHIFT = 3'd4
   } alu_cls_e;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RIGHT = 2'd1,
      SK_ARITH = 2'd2
   } shift_kind_e;

   typedef struct packed {
      logic sat;
      logic cy;
      logic ov;
      logic s;
      logic z;
   } alu_flags_t;

   localparam int FLAG_BITS = $bits(alu_flags_t);

   function automatic alu_cls_e op_class(input logic [3:0] op);
      case (op)
         OP_ADD, OP_SUB, OP_RSUB, OP_CMP: op_class = CLS_ARITH;
         OP_SADD, OP_SSUB:                op_class = CLS_SAT;
         OP_AND, OP_OR, OP_XOR, OP_NOT:   op_class = CLS_LOGIC;
         OP_SHL, OP_SHR, OP_SAR:          op_class = CLS_SHIFT;
         default:                         op_class = CLS_NONE;
      endcase
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH       = 32,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             do_sub,
   input  logic             swap,
   input  logic             sat_en,
   output logic [WIDTH-1:0] res,
   output logic             cy,
   output logic             ov,
   output logic             sat_hit
);

   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] lhs, rhs, raw;
   logic [WIDTH:0]   wide;
   logic             sign_l, sign_r, sign_o;

   // operand order: reverse subtract swaps the minuend
   assign lhs = swap ? b : a;
   assign rhs = swap ? a : b;

   always_comb begin
      if (do_sub) wide = {1'b0, lhs} - {1'b0, rhs};
      else        wide = {1'b0, lhs} + {1'b0, rhs};
   end

   assign raw    = wide[WIDTH-1:0];
   assign cy     = wide[WIDTH];
   assign sign_l = lhs[MSB];
   assign sign_r = rhs[MSB];
   assign sign_o = raw[MSB];

   always_comb begin
      if (do_sub) ov = (sign_l != sign_r) && (sign_o != sign_l);
      else        ov = (sign_l == sign_r) && (sign_o != sign_l);
   end

   generate
      if (SAT_SUPPORT) begin : g_sat
         assign sat_hit = sat_en && ov;
         // a wrapped negative value means the true result ran past the top
         assign res     = sat_hit ? (sign_o ? POS_LIMIT : NEG_LIMIT) : raw;
      end else begin : g_nosat
         logic unused_sat;
         assign unused_sat = sat_en;
         assign sat_hit    = 1'b0;
         assign res        = raw;
      end
   endgenerate

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       fn,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      case (fn)
         2'd0:    res = a & b;
         2'd1:    res = a | b;
         2'd2:    res = a ^ b;
         default: res = ~a;
      endcase
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [SHW-1:0]   amt,
   input  shift_kind_e      kind,
   output logic [WIDTH-1:0] res,
   output logic             cy
);

   logic [WIDTH-1:0] a_rev, out_fwd, out_rev;
   logic             fill;
   logic [WIDTH:0]   stg [SHW+1];

   // reverse the word so that a left shift runs through the right shifter
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_rev
         assign a_rev[i]   = a[WIDTH-1-i];
         assign out_rev[i] = out_fwd[WIDTH-1-i];
      end
   endgenerate

   assign fill   = (kind == SK_ARITH) && a[WIDTH-1];
   // a guard bit below the word catches the last bit shifted out
   assign stg[0] = {(kind == SK_LEFT) ? a_rev : a, 1'b0};

   generate
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int STEP = 1 << k;
         assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][WIDTH:STEP]} : stg[k];
      end
   endgenerate

   assign out_fwd = stg[SHW][WIDTH:1];
   assign cy      = stg[SHW][0];
   assign res     = (kind == SK_LEFT) ? out_rev : out_fwd;

endmodule

// File: rtl/alu_status.sv
module alu_status
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  alu_cls_e         cls,
   input  logic [WIDTH-1:0] res,
   input  logic             cy_in,
   input  logic             ov_in,
   input  logic             sat_in,
   output alu_flags_t       nxt,
   output alu_flags_t       cur
);

   logic res_zero, res_sign;

   assign res_zero = (res == '0);
   assign res_sign = res[WIDTH-1];

   always_comb begin
      nxt = cur;
      if (upd) begin
         case (cls)
            CLS_ARITH, CLS_SAT: begin
               nxt.z   = res_zero;
               nxt.s   = res_sign;
               nxt.cy  = cy_in;
               nxt.ov  = ov_in;
               nxt.sat = cur.sat | sat_in;
            end
            CLS_LOGIC: begin
               nxt.z  = res_zero;
               nxt.s  = res_sign;
               nxt.ov = 1'b0;
            end
            CLS_SHIFT: begin
               nxt.z  = res_zero;
               nxt.s  = res_sign;
               nxt.ov = 1'b0;
               nxt.cy = cy_in;
            end
            default: nxt = cur;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur <= '0;
      else if (upd) cur <= nxt;
   end

   // R5
   r5_sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur.sat |=> cur.sat);

   // R6
   r6_logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && cls == CLS_LOGIC) |=> (cur.cy == $past(cur.cy)) && !cur.ov);

   // R9
   r9_zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && cls != CLS_NONE) |=> (cur.z == ($past(res) == '0)));

   // R10
   r10_idle_holds_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd || cls == CLS_NONE) |=> $stable(cur));

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec_en,
   input  logic [3:0]           op_sel,
   input  logic [WIDTH-1:0]     opnd_a,
   input  logic [WIDTH-1:0]     opnd_b,
   output logic [WIDTH-1:0]     result,
   output logic                 res_wr,
   output logic [FLAG_BITS-1:0] flg_next,
   output logic [FLAG_BITS-1:0] stat_q
);

   localparam int SHW = $clog2(WIDTH);

   generate
      if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("flagged_alu: WIDTH must be a power of two of at least 8");
      end
   endgenerate

   alu_op_e          op;
   alu_cls_e         cls;
   shift_kind_e      skind;
   logic [WIDTH-1:0] as_res, lg_res, sh_res;
   logic             as_cy, as_ov, as_sat, sh_cy;
   logic             is_sub, is_swap, is_sat;
   logic             cy_sel;
   alu_flags_t       nxt_s, cur_s;

   assign op      = alu_op_e'(op_sel);
   assign cls     = op_class(op_sel);
   assign is_sub  = (op == OP_SUB) || (op == OP_RSUB) || (op == OP_CMP) || (op == OP_SSUB);
   assign is_swap = (op == OP_RSUB);
   assign is_sat  = (cls == CLS_SAT);

   always_comb begin
      case (op)
         OP_SHR:  skind = SK_RIGHT;
         OP_SAR:  skind = SK_ARITH;
         default: skind = SK_LEFT;
      endcase
   end

   alu_addsub #(.WIDTH(WIDTH), .SAT_SUPPORT(SAT_SUPPORT)) u_addsub (
      .a       (opnd_a),
      .b       (opnd_b),
      .do_sub  (is_sub),
      .swap    (is_swap),
      .sat_en  (is_sat),
      .res     (as_res),
      .cy      (as_cy),
      .ov      (as_ov),
      .sat_hit (as_sat)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (opnd_a),
      .b   (opnd_b),
      .fn  (op_sel[1:0] - 2'd2),
      .res (lg_res)
   );

   alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
      .a    (opnd_a),
      .amt  (opnd_b[SHW-1:0]),
      .kind (skind),
      .res  (sh_res),
      .cy   (sh_cy)
   );

   always_comb begin
      case (cls)
         CLS_ARITH, CLS_SAT: result = as_res;
         CLS_LOGIC:          result = lg_res;
         CLS_SHIFT:          result = sh_res;
         default:            result = '0;
      endcase
   end

   assign cy_sel = (cls == CLS_SHIFT) ? sh_cy : as_cy;

   alu_status #(.WIDTH(WIDTH)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (exec_en),
      .cls    (cls),
      .res    (result),
      .cy_in  (cy_sel),
      .ov_in  (as_ov),
      .sat_in (as_sat),
      .nxt    (nxt_s),
      .cur    (cur_s)
   );

   assign res_wr   = exec_en && (cls != CLS_NONE) && (op != OP_CMP);
   assign flg_next = nxt_s;
   assign stat_q   = cur_s;

   // R4
   r4_sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && is_sat && nxt_s.ov) |->
         (result == {1'b0, {(WIDTH-1){1'b1}}} || result == {1'b1, {(WIDTH-1){1'b0}}}));

   // R8
   r8_shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && cls == CLS_SHIFT && opnd_b[SHW-1:0] == '0) |->
         (result == opnd_a && !nxt_s.cy));

   // R11
   r11_status_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en |=> (stat_q == $past(flg_next)));

endmodule

// File: tb/flagged_alu_bench.sv
module flagged_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [3:0]  op_sel = 4'd0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [31:0] result;
   logic        res_wr;
   logic [4:0]  flg_next;
   logic [4:0]  stat_q;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   flagged_alu u_flagged_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .exec_en  (exec_en),
      .op_sel   (op_sel),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .result   (result),
      .res_wr   (res_wr),
      .flg_next (flg_next),
      .stat_q   (stat_q)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // flags written {sat, cy, ov, s, z}
   task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] er, input logic [4:0] ef, input bit ew,
                         input string tag);
      @(negedge clk);
      exec_en = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
      #1;
      chk(res_wr == ew, {tag, " write strobe"}, 32'(res_wr), 32'(ew));
      if (ew) chk(result == er, {tag, " result"}, result, er);
      chk(flg_next == ef, {tag, " next flags"}, 32'(flg_next), 32'(ef));
      @(posedge clk); #1;
      chk(stat_q == ef, {tag, " stored flags"}, 32'(stat_q), 32'(ef));
      exec_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      chk(stat_q == 5'b0, "R11 reset clears status", 32'(stat_q), 32'h0);
      chk(res_wr == 1'b0, "R10 idle strobe at reset", 32'(res_wr), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_add();
      run_op(4'd0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 5'b00110, 1'b1, "R1 add signed overflow");
      run_op(4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 5'b01001, 1'b1, "R1 R9 add unsigned carry zero");
   endtask

   task automatic t_sub();
      run_op(4'd1, 32'd5, 32'd7, 32'hFFFF_FFFE, 5'b01010, 1'b1, "R2 sub borrow");
      run_op(4'd2, 32'd5, 32'd7, 32'd2, 5'b00000, 1'b1, "R2 reverse sub");
      run_op(4'd1, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 5'b00100, 1'b1, "R2 sub overflow");
      run_op(4'd3, 32'd3, 32'd3, 32'h0, 5'b00001, 1'b0, "R3 compare equal");
      run_op(4'd3, 32'd2, 32'd9, 32'h0, 5'b01010, 1'b0, "R3 compare less");
   endtask

   task automatic t_logic();
      run_op(4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 5'b01001, 1'b1, "R6 plant carry");
      run_op(4'd6, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0, 5'b01001, 1'b1, "R6 and keeps carry");
      run_op(4'd7, 32'h8000_0000, 32'h1, 32'h8000_0001, 5'b01010, 1'b1, "R6 or sign");
      run_op(4'd8, 32'h1234_5678, 32'h1234_5678, 32'h0, 5'b01001, 1'b1, "R6 xor zero");
      run_op(4'd9, 32'h0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 5'b01010, 1'b1, "R6 not");
      run_op(4'd0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 5'b00110, 1'b1, "R6 plant overflow");
      run_op(4'd8, 32'h1, 32'h3, 32'h2, 5'b00000, 1'b1, "R6 xor clears overflow");
   endtask

   task automatic t_sat();
      run_op(4'd4, 32'h7FFF_FFF0, 32'h100, 32'h7FFF_FFFF, 5'b10100, 1'b1, "R4 sat add positive clamp");
      run_op(4'd0, 32'd1, 32'd1, 32'd2, 5'b10000, 1'b1, "R5 sat survives add");
      run_op(4'd5, 32'h8000_0000, 32'h1, 32'h8000_0000, 5'b10110, 1'b1, "R4 sat sub negative clamp");
      run_op(4'd4, 32'd1, 32'd2, 32'd3, 5'b10000, 1'b1, "R5 sat survives unclamped add");
      run_op(4'd6, 32'h0, 32'h0, 32'h0, 5'b10001, 1'b1, "R5 sat survives logic");
   endtask

   task automatic t_shift();
      run_op(4'd10, 32'h8000_0001, 32'd1, 32'h2, 5'b01000, 1'b1, "R7 shl by one");
      run_op(4'd10, 32'hF000_0001, 32'h124, 32'h10, 5'b01000, 1'b1, "R7 shl ignores upper amount");
      run_op(4'd11, 32'h3, 32'd1, 32'h1, 5'b01000, 1'b1, "R7 shr by one");
      run_op(4'd11, 32'h8000_0000, 32'd31, 32'h1, 5'b00000, 1'b1, "R7 shr by 31");
      run_op(4'd12, 32'h8000_0000, 32'd4, 32'hF800_0000, 5'b00010, 1'b1, "R7 sar fill");
      run_op(4'd12, 32'h8000_0008, 32'd4, 32'hF800_0000, 5'b01010, 1'b1, "R7 sar carry");
      run_op(4'd11, 32'h1234_5678, 32'h20, 32'h1234_5678, 5'b00000, 1'b1, "R8 shift by zero");
      run_op(4'd0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 5'b00110, 1'b1, "R7 plant overflow");
      run_op(4'd10, 32'h1, 32'h0, 32'h1, 5'b00000, 1'b1, "R7 R8 shift clears overflow");
   endtask

   task automatic t_idle();
      run_op(4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 5'b01001, 1'b1, "R10 set status");
      @(negedge clk);
      exec_en = 1'b0; op_sel = 4'd0; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h1;
      #1;
      chk(res_wr == 1'b0, "R10 disabled strobe", 32'(res_wr), 32'h0);
      @(posedge clk); #1;
      chk(stat_q == 5'b01001, "R10 disabled holds status", 32'(stat_q), 32'h9);
      run_op(4'd13, 32'h0, 32'h0, 32'h0, 5'b01001, 1'b0, "R10 reserved code");
      run_op(4'd15, 32'h5, 32'h5, 32'h0, 5'b01001, 1'b0, "R10 reserved code top");
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      do_reset();
      t_add();
      t_sub();
      t_logic();
      t_sat();
      do_reset();
      t_shift();
      t_idle();
      do_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule